// File: doc/BRIEF.md
# Floppy Byte-Transfer Stall Unit

This block lets a processor without a DMA controller move floppy-controller data one byte per I/O instruction. When the processor issues an I/O read or write into a sixteen-address window, the unit signals the floppy controller that the byte transfer is being acknowledged. It also pulls the processor's ready line low, so the bus cycle stretches in wait states until the controller has the byte. The controller's data-request line ends the wait. The wait may last as long as a full disk rotation.

The controller's interrupt line also ends the wait. An error or end-of-operation therefore never leaves the bus stuck. A stall ended this way sets a sticky flag, which tells software that the byte it just took is result-phase data and not sector data. The flag clears on an I/O read of a dedicated status address. Wait insertion depends on an enable input. With the enable low, window accesses still acknowledge the controller but complete without a stall.

The release path is combinational, so ready rises in the same clock in which the data-request or interrupt line rises. This keeps the per-byte service time well inside the high-density budget of a few microseconds. No data path passes through the block. Every pin is plain control or status, so no handshake or back-pressure rules apply.

Top module: `pdma_stall_unit`

## Requirements
- R1: While reset is asserted, `cpu_ready` is 1, `fdc_ack_n` is 1 and `int_ended` is 0, whatever the other inputs are doing.
- R2: `fdc_ack_n` is 0 exactly while `io_cycle` is 1, `addr[7:4]` equals 4'h2 (addresses 0x20 to 0x2F) and `rd_n` or `wr_n` is 0. Memory cycles (`io_cycle` = 0) and I/O addresses outside the window leave `fdc_ack_n` at 1 and `cpu_ready` at 1.
- R3: When the registered enable is 1, a window access drives `cpu_ready` to 0 from its first cycle. `cpu_ready` returns to 1 in the same clock cycle in which `fdc_drq` becomes 1.
- R4: Once a stall has been released, `cpu_ready` stays 1 for the rest of that strobe, even if `fdc_drq` or `fdc_int` falls again.
- R5: `fdc_int` at 1 also releases a stall in the same cycle, with `fdc_drq` at 0.
- R6: A stall ended by `fdc_int` with `fdc_drq` at 0 sets `int_ended` at the next clock edge. A stall ended by `fdc_drq`, including one where both lines rise together, leaves `int_ended` unchanged.
- R7: `int_ended` stays at 1 until an I/O read (`io_cycle` = 1, `rd_n` = 0) of address 0x30. It reads 0 after the next clock edge following that read. Other accesses do not clear it.
- R8: `wait_en` is registered, so a change takes effect one clock later. With it at 0, window accesses still drive `fdc_ack_n` to 0 but `cpu_ready` stays 1. Setting it again restores stalling on the next access.
- R9: `fdc_ack_n` returns to 1 in the same cycle that the strobe ends. The next window access starts a fresh stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| io_cycle | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| addr | input | 8 | Decoded I/O address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| fdc_drq | input | 1 | Controller byte-ready request |
| fdc_int | input | 1 | Controller interrupt line |
| wait_en | input | 1 | Enables wait-state insertion |
| cpu_ready | output | 1 | Ready line to the processor (0 = wait) |
| fdc_ack_n | output | 1 | Active-low transfer acknowledge to the controller |
| int_ended | output | 1 | Sticky flag: last stall ended by interrupt |

## Verification
The hardest case to reach is a stall ended by the interrupt line while the strobe stays low afterwards. The flag must set on that path, the ready line must stay high after the interrupt drops, and nothing may re-stall. The stimulus holds one window access over several cycles and raises and lowers `fdc_int` inside it. It then reads a non-status address and finally the status address, which shows that the flag persists and then clears. A second access raises both request lines in the same cycle to confirm that the data request takes priority.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_FREE = 2'd2
  } stall_st_t;
endpackage

// File: rtl/pdma_decode.sv
module pdma_decode #(
  parameter int          ADDR_W    = 8,
  parameter int          TAG_W     = 4,
  parameter logic [3:0]  WIN_TAG   = 4'h2,
  parameter logic [7:0]  STAT_ADDR = 8'h30
) (
  input  logic              io_cycle,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              win_acc,
  output logic              stat_rd
);
  localparam int TAG_LO = ADDR_W - TAG_W;

  logic tag_hit;
  logic strobe;

  always_comb begin
    tag_hit = (addr[ADDR_W-1:TAG_LO] == WIN_TAG[TAG_W-1:0]);
    strobe  = ~rd_n | ~wr_n;
    win_acc = io_cycle & tag_hit & strobe;
    stat_rd = io_cycle & ~rd_n & (addr == STAT_ADDR[ADDR_W-1:0]);
  end
endmodule

// File: rtl/pdma_stall_ctrl.sv
module pdma_stall_ctrl
  import pdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_acc,
  input  logic en_q,
  input  logic drq,
  input  logic irq,
  output logic ready_o,
  output logic int_end
);
  stall_st_t st_q, st_d;
  logic      armed;
  logic      release_now;

  always_comb begin
    armed       = win_acc & en_q & (st_q != ST_FREE);
    release_now = drq | irq;
    ready_o     = ~(armed & ~release_now);
    int_end     = armed & irq & ~drq;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (win_acc) st_d = (!en_q || release_now) ? ST_FREE : ST_HOLD;
      ST_HOLD: if (!win_acc) st_d = ST_IDLE;
               else if (release_now) st_d = ST_FREE;
      ST_FREE: if (!win_acc) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R4: a released strobe never stalls again while enable holds
  a_r4_no_restall: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && en_q && ready_o) |=> (!win_acc || !en_q || ready_o));

  // R9: end of strobe clears the released state
  a_r9_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pdma_status.sv
module pdma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic int_end,
  input  logic stat_rd,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (int_end) flag_q <= 1'b1;
    else if (stat_rd) flag_q <= 1'b0;
  end

  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    int_end |=> flag_q);

  a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !int_end) |=> !flag_q);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_rd) |=> flag_q);
endmodule

// File: rtl/pdma_stall_unit.sv
module pdma_stall_unit #(
  parameter int         ADDR_W    = 8,
  parameter int         TAG_W     = 4,
  parameter logic [3:0] WIN_TAG   = 4'h2,
  parameter logic [7:0] STAT_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_cycle,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              fdc_drq,
  input  logic              fdc_int,
  input  logic              wait_en,
  output logic              cpu_ready,
  output logic              fdc_ack_n,
  output logic              int_ended
);
  logic win_acc, stat_rd, en_q, ready_core, int_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= wait_en;
  end

  pdma_decode #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .io_cycle(io_cycle), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .win_acc(win_acc), .stat_rd(stat_rd)
  );

  pdma_stall_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_acc(win_acc), .en_q(en_q),
    .drq(fdc_drq), .irq(fdc_int), .ready_o(ready_core), .int_end(int_end)
  );

  pdma_status u_status (
    .clk(clk), .rst_n(rst_n), .int_end(int_end), .stat_rd(stat_rd),
    .flag_q(int_ended)
  );

  always_comb begin
    cpu_ready = rst_n ? ready_core : 1'b1;
    fdc_ack_n = rst_n ? ~win_acc   : 1'b1;
  end

  // R8: disabled insertion never stalls
  a_r8_disabled_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wait_en) |=> cpu_ready);

  // R5: interrupt line opens the bus in the same cycle
  a_r5_int_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_int |-> cpu_ready);
endmodule

// File: tb/pdma_stall_unit_bench.sv
module pdma_stall_unit_bench;
  localparam int PERIOD = 10;

  typedef struct {
    logic  rdy;
    logic  ack_n;
    logic  flag;
    string tag;
  } exp_t;

  logic       clk = 0, rst_n = 0;
  logic       io_cycle = 0, rd_n = 1, wr_n = 1, drq = 0, irq = 0, wen = 0;
  logic [7:0] addr = 0;
  logic       cpu_ready, fdc_ack_n, int_ended;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #(PERIOD/2) clk = ~clk;

  pdma_stall_unit u_pdma_stall_unit (
    .clk(clk), .rst_n(rst_n), .io_cycle(io_cycle), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .fdc_drq(drq), .fdc_int(irq),
    .wait_en(wen), .cpu_ready(cpu_ready), .fdc_ack_n(fdc_ack_n),
    .int_ended(int_ended)
  );

  task automatic drive(input logic io, input logic [7:0] a, input logic r,
                       input logic w, input logic d, input logic i);
    @(posedge clk); #1;
    io_cycle = io; addr = a; rd_n = r; wr_n = w; drq = d; irq = i;
  endtask

  task automatic expect_out(input logic r, input logic k, input logic f,
                            input string t);
    exp_t e;
    e.rdy = r; e.ack_n = k; e.flag = f; e.tag = t;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cpu_ready !== e.rdy || fdc_ack_n !== e.ack_n || int_ended !== e.flag) begin
        errors++;
        $display("FAIL %s: got ready=%b ack_n=%b flag=%b, expected ready=%b ack_n=%b flag=%b",
                 e.tag, cpu_ready, fdc_ack_n, int_ended, e.rdy, e.ack_n, e.flag);
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wen = 1;
    drive(1, 8'h24, 0, 1, 0, 0);          expect_out(1, 1, 0, "R1 reset");
    drive(1, 8'h24, 0, 1, 0, 0);          expect_out(1, 1, 0, "R1 reset hold");
    drive(0, 8'h00, 1, 1, 0, 0); rst_n = 1;
    drive(0, 8'h00, 1, 1, 0, 0);          expect_out(1, 1, 0, "R1 idle after reset");
    drive(1, 8'h25, 0, 1, 0, 0);          expect_out(0, 0, 0, "R3 stall start");
    drive(1, 8'h25, 0, 1, 0, 0);          expect_out(0, 0, 0, "R3 still waiting");
    drive(1, 8'h25, 0, 1, 1, 0);          expect_out(1, 0, 0, "R3 drq release");
    drive(1, 8'h25, 0, 1, 0, 0);          expect_out(1, 0, 0, "R4 stays released");
    drive(0, 8'h25, 1, 1, 0, 0);          expect_out(1, 1, 0, "R9 ack drops");
    drive(1, 8'h2F, 1, 0, 0, 0);          expect_out(0, 0, 0, "R9 R2 new write stalls");
    drive(1, 8'h2F, 1, 0, 0, 1);          expect_out(1, 0, 0, "R5 int release");
    drive(1, 8'h2F, 1, 0, 0, 0);          expect_out(1, 0, 1, "R6 flag set R4 hold");
    drive(0, 8'h00, 1, 1, 0, 0);          expect_out(1, 1, 1, "R7 sticky");
    drive(0, 8'h20, 0, 1, 0, 0);          expect_out(1, 1, 1, "R2 memory cycle");
    drive(1, 8'h1F, 0, 1, 0, 0);          expect_out(1, 1, 1, "R2 R7 outside window");
    drive(1, 8'h30, 0, 1, 0, 0);          expect_out(1, 1, 1, "R7 status read");
    drive(0, 8'h00, 1, 1, 0, 0);          expect_out(1, 1, 0, "R7 cleared");
    drive(1, 8'h21, 0, 1, 1, 1);          expect_out(1, 0, 0, "R6 both lines");
    drive(0, 8'h00, 1, 1, 0, 0);          expect_out(1, 1, 0, "R6 drq wins no flag");
    wen = 0;
    drive(0, 8'h00, 1, 1, 0, 0);
    drive(1, 8'h22, 0, 1, 0, 0);          expect_out(1, 0, 0, "R8 disabled no stall");
    drive(1, 8'h22, 0, 1, 0, 0);          expect_out(1, 0, 0, "R8 disabled hold");
    wen = 1;
    drive(0, 8'h00, 1, 1, 0, 0);
    drive(1, 8'h22, 0, 1, 0, 0);          expect_out(0, 0, 0, "R8 re-enabled stall");
    drive(1, 8'h22, 0, 1, 1, 0);          expect_out(1, 0, 0, "R3 release again");
    drive(0, 8'h00, 1, 1, 0, 0);          expect_out(1, 1, 0, "R9 end");
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule